// File: doc/BRIEF.md
# Serial Bus Wired-AND Resolver

This block models a three-line open-collector serial peripheral bus (attention, clock and data) shared by one host computer and one disk drive. Each side writes its own output register through a synchronous write strobe. The block holds those bits and forms the resolved level of each line as the wired-AND of every driver on it. A driver that is active pulls its line low. The data line has one more pull-down, an automatic attention-acknowledge term. This term is low only while the drive's acknowledge-arm bit agrees with the host's attention output.

Each side reads the resolved lines back as a combinational byte in its own bit layout. The block raises a one-cycle event pulse when the host first asserts attention. It also keeps a pending flag that stays set until the host writes attention inactive. A host-enable input models the drive being switched off. While it is low, host writes are dropped and the host read byte is zero. The drive side stays live.

Top module: `serial_line_resolver`

## Requirements
- R1: After reset every driver register is 0, so all three lines read 1, the host read byte is 0x83 (when enabled), the drive read byte is 0x85, and the event and pending outputs are 0.
- R2: The attention line equals the inverse of the host attention output alone.
- R3: The clock line is 1 only when neither the host clock output nor the drive clock output is 1.
- R4: The data line is 1 only when the host data output is 0, the drive data output is 0, and the acknowledge term (host attention XOR drive acknowledge-arm) is 0.
- R5: A drive write stores the bit-inverted byte. Inverted bit 1 is the drive data output, inverted bit 3 is the drive clock output, and inverted bit 4 is the acknowledge-arm bit.
- R6: A host port write takes the attention output from bit 7. A host control write takes the data output from bit 5 and the clock output from bit 1.
- R7: The drive read byte carries data in bit 0, clock in bit 2 and attention in bit 7. All other bits are 0.
- R8: The host read byte carries clock in bit 0, data in bit 1 and attention in bit 7. All other bits are 0.
- R9: A host port write that takes attention from 0 to 1 makes `atn_event` high for exactly the following cycle. Rewriting 1 while attention is already 1 gives no pulse.
- R10: `atn_pending` is set together with the event. It is cleared by a host port write with bit 7 equal to 0.
- R11: While `host_en` is 0, host writes leave the host outputs unchanged, and the host read byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_en | input | 1 | Drive present; gates host writes and reads |
| host_port_we | input | 1 | Host port write strobe |
| host_port_wdata | input | 8 | Host port write byte (bit 7 attention) |
| host_ctl_we | input | 1 | Host control write strobe |
| host_ctl_wdata | input | 8 | Host control write byte (bit 5 data, bit 1 clock) |
| dev_we | input | 1 | Drive port write strobe |
| dev_wdata | input | 8 | Drive port write byte, active low |
| host_rdata | output | 8 | Host read byte |
| dev_rdata | output | 8 | Drive read byte |
| line_atn | output | 1 | Resolved attention line |
| line_clk | output | 1 | Resolved clock line |
| line_data | output | 1 | Resolved data line |
| atn_event | output | 1 | One-cycle pulse on host attention assertion |
| atn_pending | output | 1 | Attention asserted and not yet released |

## Verification
The main pattern walks all 64 combinations of the six driver bits: host attention, clock and data, and drive data, clock and acknowledge-arm. These are written in one cycle, and both read bytes and all three lines are compared. This separates each pull-down from the others and exposes any swapped bit position. The walk includes both polarities of the acknowledge term, so a missing XOR or a missing inversion shows up on the data line. Separate sequences rewrite attention as 1 to tell a level from an edge, release it to clear the pending flag, and repeat writes with the host disabled to show that they leave the drive-side view unchanged.

// File: rtl/serial_line_resolver.sv
module serial_line_resolver (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_en,
  input  logic       host_port_we,
  input  logic [7:0] host_port_wdata,
  input  logic       host_ctl_we,
  input  logic [7:0] host_ctl_wdata,
  input  logic       dev_we,
  input  logic [7:0] dev_wdata,
  output logic [7:0] host_rdata,
  output logic [7:0] dev_rdata,
  output logic       line_atn,
  output logic       line_clk,
  output logic       line_data,
  output logic       atn_event,
  output logic       atn_pending
);
  localparam int HP_ATN  = 7;
  localparam int HC_DATA = 5;
  localparam int HC_CLK  = 1;
  localparam int DW_DATA = 1;
  localparam int DW_CLK  = 3;
  localparam int DW_ARM  = 4;

  logic h_atn, h_clk, h_dat;
  logic d_dat, d_clk, d_arm;
  logic [7:0] dev_inv;
  logic ack;

  assign dev_inv = ~dev_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_atn       <= 1'b0;
      h_clk       <= 1'b0;
      h_dat       <= 1'b0;
      d_dat       <= 1'b0;
      d_clk       <= 1'b0;
      d_arm       <= 1'b0;
      atn_event   <= 1'b0;
      atn_pending <= 1'b0;
    end else begin
      atn_event <= 1'b0;
      if (dev_we) begin
        d_dat <= dev_inv[DW_DATA];
        d_clk <= dev_inv[DW_CLK];
        d_arm <= dev_inv[DW_ARM];
      end
      if (host_en && host_ctl_we) begin
        h_dat <= host_ctl_wdata[HC_DATA];
        h_clk <= host_ctl_wdata[HC_CLK];
      end
      if (host_en && host_port_we) begin
        h_atn <= host_port_wdata[HP_ATN];
        if (host_port_wdata[HP_ATN] && !h_atn) begin
          atn_event   <= 1'b1;
          atn_pending <= 1'b1;
        end else if (!host_port_wdata[HP_ATN]) begin
          atn_pending <= 1'b0;
        end
      end
    end
  end

  assign ack       = h_atn ^ d_arm;
  assign line_atn  = ~h_atn;
  assign line_clk  = ~h_clk & ~d_clk;
  assign line_data = ~h_dat & ~d_dat & ~ack;

  assign host_rdata = host_en ? {line_atn, 5'b0, line_data, line_clk} : 8'h00;
  assign dev_rdata  = {line_atn, 4'b0, line_clk, 1'b0, line_data};

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    atn_event |=> !atn_event);
  a_r9_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    atn_event |-> (!line_atn && $past(line_atn)));
  a_r10_pending_with_event: assert property (@(posedge clk) disable iff (!rst_n)
    atn_event |-> atn_pending);
  a_r11_host_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(host_en) |-> ($stable(h_atn) && $stable(h_clk) && $stable(h_dat)));
  a_r4_data_ack: assert property (@(posedge clk) disable iff (!rst_n)
    line_data |-> (h_atn == d_arm));
  a_r10_pending_needs_atn: assert property (@(posedge clk) disable iff (!rst_n)
    atn_pending |-> !line_atn);
endmodule

// File: tb/serial_line_resolver_bench.sv
module serial_line_resolver_bench;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, host_en = 1'b1;
  logic host_port_we = 1'b0, host_ctl_we = 1'b0, dev_we = 1'b0;
  logic [7:0] host_port_wdata = 8'h00, host_ctl_wdata = 8'h00, dev_wdata = 8'hFF;
  logic [7:0] host_rdata, dev_rdata;
  logic line_atn, line_clk, line_data, atn_event, atn_pending;

  serial_line_resolver u_serial_line_resolver (
    .clk(clk), .rst_n(rst_n), .host_en(host_en),
    .host_port_we(host_port_we), .host_port_wdata(host_port_wdata),
    .host_ctl_we(host_ctl_we), .host_ctl_wdata(host_ctl_wdata),
    .dev_we(dev_we), .dev_wdata(dev_wdata),
    .host_rdata(host_rdata), .dev_rdata(dev_rdata),
    .line_atn(line_atn), .line_clk(line_clk), .line_data(line_data),
    .atn_event(atn_event), .atn_pending(atn_pending));

  always #(PERIOD/2) clk = ~clk;

  logic [20:0] exp_q[$];
  string tag_q[$];
  int applied = 0, fails = 0;
  bit done = 1'b0;
  event chk_ev;

  logic m_ha = 0, m_hc = 0, m_hd = 0, m_dd = 0, m_dc = 0, m_dn = 0, m_pend = 0;

  function automatic logic [20:0] model(input logic en, input logic evt);
    logic a, c, d;
    a = ~m_ha;
    c = ~m_hc & ~m_dc;
    d = ~m_hd & ~m_dd & ~(m_ha ^ m_dn);
    return {(en ? {a, 5'b0, d, c} : 8'h00), {a, 4'b0, c, 1'b0, d}, a, c, d, evt, m_pend};
  endfunction

  task automatic fail(input string req, input string what, input int act, input int exp, input string tag);
    fails++;
    $display("FAIL %s (%s, %s): actual %0h expected %0h", req, what, tag, act, exp);
  endtask

  task automatic push_check(input string tag, input logic evt);
    exp_q.push_back(model(host_en, evt));
    tag_q.push_back(tag);
    -> chk_ev;
  endtask

  task automatic apply(input logic pw, input logic [7:0] pd, input logic cw, input logic [7:0] cd,
                       input logic dw, input logic [7:0] dd, input string tag);
    logic evt;
    @(negedge clk);
    host_port_we = pw; host_port_wdata = pd;
    host_ctl_we = cw;  host_ctl_wdata = cd;
    dev_we = dw;       dev_wdata = dd;
    evt = 1'b0;
    if (dw) begin m_dd = ~dd[1]; m_dc = ~dd[3]; m_dn = ~dd[4]; end
    if (host_en && cw) begin m_hd = cd[5]; m_hc = cd[1]; end
    if (host_en && pw) begin
      if (pd[7] && !m_ha) begin evt = 1'b1; m_pend = 1'b1; end
      else if (!pd[7]) m_pend = 1'b0;
      m_ha = pd[7];
    end
    @(posedge clk); #1;
    host_port_we = 0; host_ctl_we = 0; dev_we = 0;
    push_check(tag, evt);
  endtask

  initial begin
    forever begin
      logic [20:0] e;
      string t;
      @(chk_ev);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      applied++;
      if (host_rdata !== e[20:13]) fail("R8", "host_rdata", host_rdata, e[20:13], t);
      if (dev_rdata !== e[12:5])   fail("R7", "dev_rdata", dev_rdata, e[12:5], t);
      if (line_atn !== e[4])       fail("R2", "line_atn", line_atn, e[4], t);
      if (line_clk !== e[3])       fail("R3", "line_clk", line_clk, e[3], t);
      if (line_data !== e[2])      fail("R4", "line_data", line_data, e[2], t);
      if (atn_event !== e[1])      fail("R9", "atn_event", atn_event, e[1], t);
      if (atn_pending !== e[0])    fail("R10", "atn_pending", atn_pending, e[0], t);
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 push_check("R1 reset", 1'b0);
    @(negedge clk);
    // R5 R6: walk all six driver bits
    for (int v = 0; v < 64; v++) begin
      logic [7:0] pd, cd, dd;
      pd = {v[0], 7'b0};
      cd = {2'b0, v[2], 3'b0, v[1], 1'b0};
      dd = ~{3'b0, v[5], v[4], 1'b0, v[3], 1'b0};
      apply(1, pd, 1, cd, 1, dd, "R5 R6 walk");
    end
    apply(1, 8'h00, 0, 8'h00, 1, 8'hFF, "R10 release");
    apply(1, 8'h80, 0, 8'h00, 0, 8'h00, "R9 rise");
    apply(0, 8'h00, 0, 8'h00, 0, 8'h00, "R9 pulse ends");
    apply(1, 8'h80, 0, 8'h00, 0, 8'h00, "R9 rewrite high");
    apply(1, 8'h7F, 0, 8'h00, 0, 8'h00, "R10 clear by bit7 low");
    apply(0, 8'h00, 1, 8'h22, 1, 8'hE5, "R5 R6 mixed");
    @(negedge clk); host_en = 1'b0;
    #1 push_check("R11 disabled idle", 1'b0);
    apply(1, 8'h80, 1, 8'h00, 0, 8'h00, "R11 writes ignored");
    apply(1, 8'hFF, 1, 8'hFF, 1, 8'hFF, "R11 drive still live");
    @(negedge clk); host_en = 1'b1;
    #1 push_check("R11 re-enabled", 1'b0);
    apply(1, 8'h80, 1, 8'h20, 1, 8'hEF, "R4 ack agree");
    apply(0, 8'h00, 1, 8'h00, 1, 8'hFF, "R4 ack disagree");
    @(negedge clk);
    finish_run();
  end
endmodule